// File: doc/BRIEF.md
# Split-Access 64-bit Register Bridge

This block gives a 32-bit memory-mapped slave port access to a small bank of 64-bit registers. Each register occupies a slot of two 32-bit words: word address bit 0 selects the word at byte offset +0x0 (bit clear) or +0x4 (bit set), and the bits above select the slot. A write to the +0x0 word is only staged. The next write to the +0x4 word joins the staged word and the new word and commits all 64 bits in one clock. Software therefore writes the +0x0 word first and the +0x4 word second.

Reads are tear-free. Reading the +0x0 word captures the whole 64-bit value of that slot into a shadow register, and a following read of the +0x4 word of the same slot returns the companion half from the shadow. This keeps a free-running event counter consistent even when a carry crosses the 32-bit boundary between the two reads. A static strap selects which offset carries the upper half. Slot 0 is a configuration register whose bit 31 requests a one-clock soft reset that clears the event counters. Slot 1 is a plain read/write register. Slots 2 and up are 64-bit event counters, one per event input, which can also be preloaded by a commit.

Top module: `wide_reg_bridge`

## Requirements
- R1: After reset every word of every slot reads as zero, `bus_rvalid` is low and `soft_rst_pulse` is low.
- R2: A write to a +0x0 word leaves every stored register unchanged. A read between that write and its +0x4 write returns the old value and does not disturb the staged word.
- R3: With `word_swap`=0, a write to the +0x4 word commits {staged word, written word} as bits 63..32 and 31..0 in the clock of that write. The +0x0 word of a slot reads bits 63..32 and the +0x4 word reads bits 31..0.
- R4: With `word_swap`=1, the roles are exchanged: the +0x0 word is bits 31..0 and the +0x4 word is bits 63..32, both for commits and for reads.
- R5: The staging word is zero after reset and after every commit, so a lone +0x4 write commits zero into the other half.
- R6: A read of a +0x0 word captures the 64-bit value of its slot. A read of the +0x4 word of the same slot that immediately follows among reads returns the captured half, even if the counter has since moved or carried.
- R7: A +0x4 read with no capture pending for that slot (no preceding +0x0 read, a different slot, or a second +0x4 read) returns live data.
- R8: Event counter i (slot 2+i) adds one for every clock in which `event_in[i]` is high. A commit to its slot loads the committed value instead.
- R9: A commit to slot 0 whose bits 31..0 have bit 31 set raises `soft_rst_pulse` for exactly one clock, starting in the clock after the commit. In that clock all counters clear, taking priority over events. Slot 0 stores the committed value with bit 31 reading back as 0. Bit 31 of the upper half does not trigger a reset.
- R10: With `word_swap`=0, a lone +0x4 write of 0x80000000 to slot 0 triggers the soft reset.
- R11: Read data appears on `bus_rdata` with `bus_rvalid` high in the clock after the read request. `bus_rvalid` is low after a write or an idle clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_swap | input | 1 | Static strap: 0 puts bits 63..32 at +0x0, 1 puts bits 31..0 at +0x0 |
| bus_valid | input | 1 | Request valid for this clock |
| bus_write | input | 1 | 1 write, 0 read |
| bus_waddr | input | AW (3) | Word address: {slot, word select} |
| bus_wdata | input | 32 | Write data |
| event_in | input | NUM_CNT (2) | One event per counter per clock |
| bus_rdata | output | 32 | Read data, registered |
| bus_rvalid | output | 1 | Read data valid |
| soft_rst_pulse | output | 1 | One-clock soft reset pulse |

## Verification
The bench preloads a counter just below a 32-bit carry, reads its +0x0 word, and lets events run past the carry before reading +0x4. A design without the shadow returns the wrapped live lower half, and a design that keeps the shadow too long returns stale data on the repeated +0x4 read. Both word orders are swept with several patterns, and preloading near a carry exposes a swapped-order bug as misplaced halves. The soft reset is driven with bit 31 in each half, with a lone +0x4 write, and with events high in the pulse clock. A design that leaves the staged word uncleared, lets events win over the clear, or stretches the pulse shows a wrong count or pulse level.

// File: rtl/wrb_pkg.sv
package wrb_pkg;
  localparam int WORD_W = 32;
  localparam int DWORD_W = 2 * WORD_W;
  localparam int RST_BIT = 31;

  typedef logic [DWORD_W-1:0] dword_t;
  typedef logic [WORD_W-1:0]  word_t;

  // join the +0x0 word and the +0x4 word into one 64-bit value
  function automatic dword_t join_words(input logic swap, input word_t w_lo_addr,
                                        input word_t w_hi_addr);
    return swap ? {w_hi_addr, w_lo_addr} : {w_lo_addr, w_hi_addr};
  endfunction

  // word seen at +0x0 (hi_addr=0) or +0x4 (hi_addr=1)
  function automatic word_t pick_word(input logic swap, input dword_t v,
                                      input logic hi_addr);
    return (swap ^ hi_addr) ? v[WORD_W-1:0] : v[DWORD_W-1:WORD_W];
  endfunction
endpackage

// File: rtl/wrb_stage.sv
module wrb_stage
  import wrb_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   wr_en,
  input  logic   hi_word,
  input  logic   swap,
  input  word_t  wdata,
  output logic   commit,
  output dword_t commit_val
);
  word_t stage_q, stage_d;
  logic  stage_en;

  always_comb begin
    stage_en = wr_en;
    stage_d  = hi_word ? '0 : wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        stage_q <= '0;
    else if (stage_en) stage_q <= stage_d;
  end

  assign commit     = wr_en & hi_word;
  assign commit_val = join_words(swap, stage_q, wdata);

  assert_stage_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> stage_q == '0);
  assert_stage_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(stage_q));
endmodule

// File: rtl/wrb_counter.sv
module wrb_counter
  import wrb_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   clr,
  input  logic   load,
  input  dword_t load_val,
  input  logic   inc,
  output dword_t count
);
  dword_t cnt_q, cnt_d;
  logic   cnt_en;

  always_comb begin
    cnt_en = clr | load | inc;
    if (clr)       cnt_d = '0;
    else if (load) cnt_d = load_val;
    else           cnt_d = cnt_q + dword_t'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count = cnt_q;

  assert_count_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !load && inc) |=> cnt_q == $past(cnt_q) + dword_t'(1));
  assert_count_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt_q == '0);
endmodule

// File: rtl/wrb_reader.sv
module wrb_reader
  import wrb_pkg::*;
#(
  parameter int SLOT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              hi_word,
  input  logic              swap,
  input  logic [SLOT_W-1:0] slot,
  input  dword_t            live,
  output word_t             rdata,
  output logic              rvalid
);
  dword_t            shadow_q;
  logic [SLOT_W-1:0] shadow_slot_q;
  logic              shadow_ok_q, shadow_ok_d;
  logic              cap_en;
  word_t             rdata_q, rdata_d;
  logic              rvalid_q;

  always_comb begin
    cap_en = rd_en & ~hi_word;
    shadow_ok_d = shadow_ok_q;
    if (rd_en) shadow_ok_d = ~hi_word;
    if (!hi_word)
      rdata_d = pick_word(swap, live, 1'b0);
    else if (shadow_ok_q && shadow_slot_q == slot)
      rdata_d = pick_word(swap, shadow_q, 1'b1);
    else
      rdata_d = pick_word(swap, live, 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q      <= '0;
      shadow_slot_q <= '0;
    end else if (cap_en) begin
      shadow_q      <= live;
      shadow_slot_q <= slot;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_ok_q <= 1'b0;
      rvalid_q    <= 1'b0;
      rdata_q     <= '0;
    end else begin
      shadow_ok_q <= shadow_ok_d;
      rvalid_q    <= rd_en;
      if (rd_en) rdata_q <= rdata_d;
    end
  end

  assign rdata  = rdata_q;
  assign rvalid = rvalid_q;

  assert_rvalid_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rvalid);
  assert_rvalid_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rvalid);
  assert_capture_armed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !hi_word) |=> shadow_ok_q);
  assert_capture_spent_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && hi_word) |=> !shadow_ok_q);
endmodule

// File: rtl/wide_reg_bridge.sv
module wide_reg_bridge
  import wrb_pkg::*;
#(
  parameter  int NUM_CNT = 2,
  localparam int NSLOT   = 2 + NUM_CNT,
  localparam int SLOT_W  = $clog2(NSLOT),
  localparam int AW      = SLOT_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               word_swap,
  input  logic               bus_valid,
  input  logic               bus_write,
  input  logic [AW-1:0]      bus_waddr,
  input  logic [31:0]        bus_wdata,
  input  logic [NUM_CNT-1:0] event_in,
  output logic [31:0]        bus_rdata,
  output logic               bus_rvalid,
  output logic               soft_rst_pulse
);
  localparam logic [SLOT_W-1:0] CFG_SLOT  = SLOT_W'(0);
  localparam logic [SLOT_W-1:0] SCR_SLOT  = SLOT_W'(1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic              wr_en, rd_en, hi_word;
  logic [SLOT_W-1:0] slot;
  logic              commit;
  dword_t            commit_val;

  assign wr_en   = bus_valid & bus_write;
  assign rd_en   = bus_valid & ~bus_write;
  assign hi_word = bus_waddr[0];
  assign slot    = bus_waddr[AW-1:1];

  wrb_stage u_stage (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .wr_en     (wr_en),
    .hi_word   (hi_word),
    .swap      (word_swap),
    .wdata     (bus_wdata),
    .commit    (commit),
    .commit_val(commit_val)
  );

  // configuration and scratch registers
  dword_t cfg_q, cfg_d, scr_q;
  logic   cfg_en, scr_en, pulse_q, pulse_d;

  always_comb begin
    cfg_en  = commit && slot == CFG_SLOT;
    scr_en  = commit && slot == SCR_SLOT;
    cfg_d   = commit_val;
    cfg_d[RST_BIT] = 1'b0;
    pulse_d = cfg_en & commit_val[RST_BIT];
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  cfg_q <= '0;
    else if (cfg_en) cfg_q <= cfg_d;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  scr_q <= '0;
    else if (scr_en) scr_q <= commit_val;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) pulse_q <= 1'b0;
    else            pulse_q <= pulse_d;
  end

  assign soft_rst_pulse = pulse_q;

  // event counters
  dword_t cnt [NUM_CNT];
  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    logic ld;
    assign ld = commit && slot == SLOT_W'(2 + i);
    wrb_counter u_cnt (
      .clk     (clk),
      .rst_n   (rst_int_n),
      .clr     (pulse_q),
      .load    (ld),
      .load_val(commit_val),
      .inc     (event_in[i]),
      .count   (cnt[i])
    );
  end

  // live value of the addressed slot
  dword_t live;
  always_comb begin
    live = '0;
    if (slot == CFG_SLOT) live = cfg_q;
    if (slot == SCR_SLOT) live = scr_q;
    for (int i = 0; i < NUM_CNT; i++)
      if (slot == SLOT_W'(2 + i)) live = cnt[i];
  end

  wrb_reader #(.SLOT_W(SLOT_W)) u_reader (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .rd_en  (rd_en),
    .hi_word(hi_word),
    .swap   (word_swap),
    .slot   (slot),
    .live   (live),
    .rdata  (bus_rdata),
    .rvalid (bus_rvalid)
  );

  assert_reset_fires_R10: assert property (@(posedge clk) disable iff (!rst_int_n)
    (commit && slot == CFG_SLOT && commit_val[RST_BIT]) |=> soft_rst_pulse);
  assert_no_false_reset_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(commit && slot == CFG_SLOT) |=> !soft_rst_pulse);
  assert_bit_selfclear_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    cfg_en |=> cfg_q[RST_BIT] == 1'b0);
endmodule

// File: tb/sim_wide_reg_bridge.sv
module sim_wide_reg_bridge;
  localparam int AW = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        word_swap = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [AW-1:0] bus_waddr = '0;
  logic [31:0] bus_wdata = '0;
  logic [1:0]  event_in = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid, soft_rst_pulse;

  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  wide_reg_bridge u0 (
    .clk(clk), .rst_n(rst_n), .word_swap(word_swap), .bus_valid(bus_valid),
    .bus_write(bus_write), .bus_waddr(bus_waddr), .bus_wdata(bus_wdata),
    .event_in(event_in), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .soft_rst_pulse(soft_rst_pulse)
  );

  // bench-side model state
  logic [63:0] mcnt [2];
  logic [31:0] mstage = '0;
  bit          clr_pend = 0;
  logic [31:0] last_rd;
  logic        last_rv;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic op(input logic v, input logic w, input logic [AW-1:0] a,
                    input logic [31:0] d, input logic [1:0] ev);
    logic [63:0] cv;
    bit commit;
    @(negedge clk);
    bus_valid = v; bus_write = w; bus_waddr = a; bus_wdata = d; event_in = ev;
    @(posedge clk);
    commit = v && w && a[0];
    cv = word_swap ? {d, mstage} : {mstage, d};
    for (int i = 0; i < 2; i++) begin
      if (clr_pend) mcnt[i] = '0;
      else if (commit && a[AW-1:1] == 2'(2 + i)) mcnt[i] = cv;
      else mcnt[i] = mcnt[i] + 64'(ev[i]);
    end
    clr_pend = commit && a[AW-1:1] == 2'd0 && cv[31];
    if (v && w) mstage = a[0] ? 32'h0 : d;
    #2;
    last_rd = bus_rdata;
    last_rv = bus_rvalid;
    bus_valid = 1'b0;
    event_in = '0;
  endtask

  task automatic wr(input int s, input int k, input logic [31:0] d);
    op(1'b1, 1'b1, AW'(s * 2 + k), d, 2'b00);
  endtask

  task automatic rd(input int s, input int k, input logic [1:0] ev);
    op(1'b1, 1'b0, AW'(s * 2 + k), 32'h0, ev);
  endtask

  task automatic idle(input logic [1:0] ev);
    op(1'b0, 1'b0, '0, 32'h0, ev);
  endtask

  function automatic logic [31:0] word_of(input logic sw, input logic [63:0] v, input int k);
    return ((sw ? 1 : 0) ^ k) != 0 ? v[31:0] : v[63:32];
  endfunction

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [63:0] v, nv;
    logic [31:0] x, y;
    int n0, n1;
    mcnt[0] = '0; mcnt[1] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    chk("R1 pulse", {31'h0, soft_rst_pulse}, 32'h0);
    for (int s = 0; s < 4; s++)
      for (int k = 0; k < 2; k++) begin
        rd(s, k, 2'b00);
        chk("R1 read", last_rd, 32'h0);
        chk("R11 rvalid after read", {31'h0, last_rv}, 32'h1);
      end
    idle(2'b00);
    chk("R11 rvalid idle", {31'h0, last_rv}, 32'h0);

    // R2 R3 R4: sweep scratch over both word orders
    v = '0;
    for (int sw = 0; sw < 2; sw++) begin
      word_swap = sw[0];
      for (int p = 0; p < 4; p++) begin
        x = 32'h1357_0000 + 32'(p * 32'h0101_0011) + 32'(sw);
        y = ~x ^ 32'(p << 8);
        wr(1, 0, x);
        chk("R11 rvalid after write", {31'h0, last_rv}, 32'h0);
        rd(1, 0, 2'b00);
        chk("R2 staged not visible w0", last_rd, word_of(sw[0], v, 0));
        rd(1, 1, 2'b00);
        chk("R2 staged not visible w4", last_rd, word_of(sw[0], v, 1));
        wr(1, 1, y);
        nv = sw[0] ? {y, x} : {x, y};
        rd(1, 0, 2'b00);
        chk(sw ? "R4 scratch w0" : "R3 scratch w0", last_rd, word_of(sw[0], nv, 0));
        rd(1, 1, 2'b00);
        chk(sw ? "R4 scratch w4" : "R3 scratch w4", last_rd, word_of(sw[0], nv, 1));
        v = nv;
      end
    end

    // R5: lone +0x4 write commits zero in the other half
    word_swap = 1'b0;
    idle(2'b00);
    wr(1, 1, 32'hCAFE_0001);
    rd(1, 0, 2'b00);
    chk("R5 lone write upper zero", last_rd, 32'h0);
    rd(1, 1, 2'b00);
    chk("R5 lone write lower", last_rd, 32'hCAFE_0001);

    // R8: event counting
    n0 = 0; n1 = 0;
    for (int i = 0; i < 20; i++) begin
      idle({(i % 2) == 0, (i % 3) == 0});
      if (i % 3 == 0) n0++;
      if (i % 2 == 0) n1++;
    end
    rd(2, 0, 2'b00);
    chk("R8 cnt0 upper", last_rd, 32'h0);
    rd(2, 1, 2'b00);
    chk("R8 cnt0 count", last_rd, 32'(n0));
    rd(3, 0, 2'b00);
    rd(3, 1, 2'b00);
    chk("R8 cnt1 count", last_rd, 32'(n1));

    // R6 R7: snapshot across a carry, default order
    wr(2, 0, 32'h0);
    wr(2, 1, 32'hFFFF_FFFD);
    rd(2, 0, 2'b01);
    chk("R6 upper before carry", last_rd, 32'h0);
    idle(2'b01); idle(2'b01); idle(2'b01);
    rd(2, 1, 2'b00);
    chk("R6 shadow lower", last_rd, 32'hFFFF_FFFD);
    rd(2, 1, 2'b00);
    chk("R7 second read live", last_rd, 32'h0000_0001);
    rd(2, 0, 2'b00);
    chk("R8 carry into upper", last_rd, 32'h1);
    chk("R8 model agrees", mcnt[0][63:32], 32'h1);
    wr(3, 0, 32'h0);
    wr(3, 1, 32'h0000_0040);
    rd(2, 0, 2'b10);
    idle(2'b10);
    rd(3, 1, 2'b00);
    chk("R7 other slot live", last_rd, 32'h0000_0042);

    // R4: swapped order on a counter with a carry
    word_swap = 1'b1;
    idle(2'b00);
    wr(3, 0, 32'hFFFF_FFFF);
    wr(3, 1, 32'h0000_0007);
    idle(2'b10);
    rd(3, 0, 2'b00);
    chk("R4 cnt1 lower at +0", last_rd, 32'h0);
    rd(3, 1, 2'b00);
    chk("R4 cnt1 upper at +4", last_rd, 32'h8);

    // R9: soft reset via commit, default order
    word_swap = 1'b0;
    idle(2'b00);
    wr(0, 0, 32'h0000_1234);
    wr(0, 1, 32'h8000_0005);
    chk("R9 pulse high", {31'h0, soft_rst_pulse}, 32'h1);
    idle(2'b11);
    chk("R9 pulse one clock", {31'h0, soft_rst_pulse}, 32'h0);
    rd(2, 0, 2'b00);
    rd(2, 1, 2'b00);
    chk("R9 cnt0 cleared", last_rd, 32'h0);
    rd(3, 1, 2'b00);
    chk("R9 cnt1 cleared", last_rd, 32'h0);
    rd(0, 0, 2'b00);
    chk("R9 cfg upper", last_rd, 32'h0000_1234);
    rd(0, 1, 2'b00);
    chk("R9 cfg bit self-clears", last_rd, 32'h0000_0005);
    wr(0, 0, 32'h8000_0000);
    wr(0, 1, 32'h0);
    chk("R9 upper bit31 no pulse", {31'h0, soft_rst_pulse}, 32'h0);
    rd(0, 0, 2'b00);
    chk("R9 upper bit31 stored", last_rd, 32'h8000_0000);

    // R10: lone high write triggers reset
    idle(2'b01);
    wr(0, 1, 32'h8000_0000);
    chk("R10 lone write pulse", {31'h0, soft_rst_pulse}, 32'h1);
    idle(2'b00);
    rd(0, 0, 2'b00);
    chk("R10 upper zero", last_rd, 32'h0);
    rd(2, 1, 2'b00);
    chk("R10 cnt0 cleared", last_rd, 32'h0);

    // R4 with R9: swapped order puts the reset bit at +0
    word_swap = 1'b1;
    idle(2'b00);
    wr(0, 0, 32'h8000_0000);
    wr(0, 1, 32'h0);
    chk("R4 swapped reset pulse", {31'h0, soft_rst_pulse}, 32'h1);
    idle(2'b00);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule